// File: doc/BRIEF.md
# Scalar Buffer Load Address Generator

This block turns a scalar buffer load into a memory request. Each input carries a 128-bit buffer resource descriptor, an immediate flag, an instruction offset field, a width code and a destination register index. The offset is either the zero-extended instruction field or, when the immediate flag is clear, a 32-bit value read from the scalar register that the field's low bits name. The block exposes that register index and takes the read value back in the same cycle.

The chosen offset is limited to the end of the buffer. The descriptor stride decides which of two clamping rules applies. The clamped offset is then added to the descriptor base, and the sum is rounded down to a dword boundary. The result is held in one request register and offered to a request queue through a valid/ready handshake.

A counter tracks loads that have been issued but not completed. A completion pulse lowers the counter, and the counter cannot go below zero. New work is refused when the counter together with the held request would exceed the configured limit.

Top module: `sbuf_addr_gen`

## Requirements
- R1: When `in_imm` is 1, the offset is `in_off_field` zero-extended to 32 bits, and `sreg_rdata` has no effect. When `in_imm` is 0, the offset is `sreg_rdata`. In both modes `sreg_sel` equals the low SREG_W bits of `in_off_field`.
- R2: With a descriptor stride of zero, an offset greater than or equal to the record count is replaced by the record count.
- R3: With a nonzero stride, an offset strictly greater than stride × record count is replaced by that product. The product is formed at 46 bits without truncation.
- R4: Any offset that neither clamping rule catches is used unchanged. This includes an offset exactly equal to stride × record count.
- R5: `req_addr` equals (base + clamped offset) modulo 2^48 with bits [1:0] forced to 0. The descriptor fields are base [47:0], stride [61:48] and record count [95:64]. Bits 62, 63 and [127:96] have no effect.
- R6: An input accepted on a clock edge (`in_valid` and `in_ready` both high) appears on `req_valid` with its address after that edge, one cycle of latency.
- R7: While `req_valid` is high and `req_ready` is low, the request and its fields hold stable and `in_ready` is low.
- R8: `req_dwords` is 2^`in_size` for codes 0 to 4 (1, 2, 4, 8 and 16 dwords), and 16 for codes 5 to 7. `req_dst` carries `in_dst` unchanged.
- R9: `outst_cnt` rises by one on each issued request (`req_valid` and `req_ready`) and falls by one on each `done` pulse. When both happen in the same cycle, it is unchanged.
- R10: A `done` pulse while `outst_cnt` is 0 and no request is issuing is ignored, so the counter stays at 0.
- R11: `in_ready` is low whenever `outst_cnt` plus the held request would reach MAX_OUTST. An `in_valid` raised then produces no request.
- R12: After reset, `req_valid` is 0, `outst_cnt` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Load presented |
| in_ready | output | 1 | Load accepted this cycle when valid |
| in_desc | input | 128 | Buffer resource descriptor |
| in_imm | input | 1 | 1: offset from field, 0: from scalar register |
| in_off_field | input | OFF_W | Instruction offset field |
| sreg_sel | output | SREG_W | Scalar register index for the offset read |
| sreg_rdata | input | 32 | Scalar register value for `sreg_sel` |
| in_size | input | 3 | Load width code |
| in_dst | input | DST_W | First destination scalar register |
| req_valid | output | 1 | Request offered to queue |
| req_ready | input | 1 | Queue accepts request |
| req_addr | output | 48 | Dword-aligned byte address |
| req_dwords | output | MAX_LOG+1 | Number of dwords to load |
| req_dst | output | DST_W | First destination scalar register |
| done | input | 1 | One load completed |
| outst_cnt | output | $clog2(MAX_OUTST+1) | Outstanding loads |

## Verification
The bench builds the block with MAX_OUTST set to 4, so the admission limit is reached after four issued loads without completions. That makes the stall and the simultaneous issue-and-complete case short to reach. OFF_W is 20 and SREG_W is 7, so the field's upper bits differ from the register index and the two offset sources can be told apart. The default MAX_LOG of 4 makes the 16-dword load the widest code, and codes 5 to 7 exercise the saturation to that width.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
    localparam int ADDR_W   = 48;
    localparam int STRIDE_W = 14;
    localparam int REC_W    = 32;
    localparam int OFF32_W  = 32;
    localparam int PROD_W   = STRIDE_W + REC_W;

    typedef struct packed {
        logic [REC_W-1:0]    records;
        logic [STRIDE_W-1:0] stride;
        logic [ADDR_W-1:0]   base;
    } bufdesc_t;

    function automatic bufdesc_t unpack_desc(input logic [127:0] raw);
        bufdesc_t d;
        d.base    = raw[47:0];
        d.stride  = raw[61:48];
        d.records = raw[95:64];
        return d;
    endfunction
endpackage

// File: rtl/sbuf_off_sel.sv
module sbuf_off_sel #(
    parameter int OFF_W  = 20,
    parameter int SREG_W = 7
) (
    input  logic              imm,
    input  logic [OFF_W-1:0]  field,
    input  logic [31:0]       sreg_rdata,
    output logic [SREG_W-1:0] sreg_sel,
    output logic [31:0]       offset
);
    assign sreg_sel = field[SREG_W-1:0];

    always_comb begin
        if (imm) offset = 32'(field);
        else     offset = sreg_rdata;
    end
endmodule

// File: rtl/sbuf_clamp.sv
module sbuf_clamp
    import sbuf_pkg::*;
(
    input  bufdesc_t            desc,
    input  logic [OFF32_W-1:0]  offset,
    output logic [ADDR_W-1:0]   addr
);
    logic [PROD_W-1:0] limit_prod;
    logic [PROD_W-1:0] off_wide;
    logic [PROD_W-1:0] clamped;
    logic [ADDR_W-1:0] sum;

    assign limit_prod = PROD_W'(desc.stride) * PROD_W'(desc.records);
    assign off_wide   = PROD_W'(offset);

    always_comb begin
        clamped = off_wide;
        if (desc.stride == '0) begin
            if (off_wide >= PROD_W'(desc.records)) clamped = PROD_W'(desc.records);
        end else if (off_wide > limit_prod) begin
            clamped = limit_prod;
        end
        sum  = desc.base + ADDR_W'(clamped);
        addr = {sum[ADDR_W-1:2], 2'b00};
    end
endmodule

// File: rtl/sbuf_req_track.sv
module sbuf_req_track #(
    parameter int MAX_OUTST = 15,
    localparam int CNT_W    = $clog2(MAX_OUTST + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic             done,
    input  logic             held,
    output logic             room,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             done_ok;

    always_comb begin
        done_ok = done && ((cnt_q != '0) || issue);
        cnt_d   = cnt_q;
        case ({issue, done_ok})
            2'b10:   cnt_d = cnt_q + 1'b1;
            2'b01:   cnt_d = cnt_q - 1'b1;
            default: cnt_d = cnt_q;
        endcase
        room = (({1'b0, cnt_q} + (CNT_W+1)'(held)) < (CNT_W+1)'(MAX_OUTST));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !issue) |=> (cnt_q == '0)); // R10
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !done) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R9
    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q <= CNT_W'(MAX_OUTST))); // R11
endmodule

// File: rtl/sbuf_addr_gen.sv
module sbuf_addr_gen
    import sbuf_pkg::*;
#(
    parameter int OFF_W     = 20,
    parameter int SREG_W    = 7,
    parameter int DST_W     = 7,
    parameter int MAX_LOG   = 4,
    parameter int MAX_OUTST = 15,
    localparam int DW_W     = MAX_LOG + 1,
    localparam int CNT_W    = $clog2(MAX_OUTST + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [127:0]      in_desc,
    input  logic              in_imm,
    input  logic [OFF_W-1:0]  in_off_field,
    output logic [SREG_W-1:0] sreg_sel,
    input  logic [31:0]       sreg_rdata,
    input  logic [2:0]        in_size,
    input  logic [DST_W-1:0]  in_dst,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DW_W-1:0]   req_dwords,
    output logic [DST_W-1:0]  req_dst,
    input  logic              done,
    output logic [CNT_W-1:0]  outst_cnt
);
    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [DW_W-1:0]   dwords;
        logic [DST_W-1:0]  dst;
    } stage_t;

    stage_t            st_d, st_q;
    bufdesc_t          desc;
    logic [31:0]       offset;
    logic [ADDR_W-1:0] addr_c;
    logic [DW_W-1:0]   dwords_c;
    logic              fire, accept, room;
    logic              unused_desc_bits;

    assign desc             = unpack_desc(in_desc);
    assign unused_desc_bits = ^{in_desc[127:96], in_desc[63:62]};

    sbuf_off_sel #(.OFF_W(OFF_W), .SREG_W(SREG_W)) u_off_sel (
        .imm        (in_imm),
        .field      (in_off_field),
        .sreg_rdata (sreg_rdata),
        .sreg_sel   (sreg_sel),
        .offset     (offset)
    );

    sbuf_clamp u_clamp (
        .desc   (desc),
        .offset (offset),
        .addr   (addr_c)
    );

    sbuf_req_track #(.MAX_OUTST(MAX_OUTST)) u_track (
        .clk   (clk),
        .rst_n (rst_n),
        .issue (fire),
        .done  (done),
        .held  (st_q.valid),
        .room  (room),
        .cnt   (outst_cnt)
    );

    always_comb begin
        if (32'(in_size) > MAX_LOG) dwords_c = DW_W'(1) << MAX_LOG;
        else                        dwords_c = DW_W'(1) << in_size;

        fire     = st_q.valid && req_ready;
        in_ready = (!st_q.valid || req_ready) && room;
        accept   = in_valid && in_ready;

        st_d = st_q;
        if (fire) st_d.valid = 1'b0;
        if (accept) begin
            st_d.valid  = 1'b1;
            st_d.addr   = addr_c;
            st_d.dwords = dwords_c;
            st_d.dst    = in_dst;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_valid  = st_q.valid;
    assign req_addr   = st_q.addr;
    assign req_dwords = st_q.dwords;
    assign req_dst    = st_q.dst;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_dwords))); // R7
    AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_addr[1:0] == 2'b00)); // R5
    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> req_valid); // R6
    AST_STALL_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |-> !in_ready); // R7
endmodule

// File: tb/test_sbuf_addr_gen.sv
module test_sbuf_addr_gen;
    localparam int OFF_W = 20, SREG_W = 7, DST_W = 7, MAX_LOG = 4, MAX_OUTST = 4;
    localparam int CNT_W = $clog2(MAX_OUTST + 1);

    logic clk = 0, rst_n = 0;
    logic in_valid = 0, in_imm = 0, req_ready = 1, done = 0;
    logic [127:0] in_desc = '0;
    logic [OFF_W-1:0] in_off_field = '0;
    logic [31:0] sreg_rdata = '0;
    logic [2:0] in_size = '0;
    logic [DST_W-1:0] in_dst = '0;
    logic in_ready, req_valid;
    logic [SREG_W-1:0] sreg_sel;
    logic [47:0] req_addr;
    logic [MAX_LOG:0] req_dwords;
    logic [DST_W-1:0] req_dst;
    logic [CNT_W-1:0] outst_cnt;

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    sbuf_addr_gen #(.OFF_W(OFF_W), .SREG_W(SREG_W), .DST_W(DST_W),
                    .MAX_LOG(MAX_LOG), .MAX_OUTST(MAX_OUTST)) i_sbuf_addr_gen (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_desc(in_desc), .in_imm(in_imm), .in_off_field(in_off_field),
        .sreg_sel(sreg_sel), .sreg_rdata(sreg_rdata), .in_size(in_size),
        .in_dst(in_dst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_dwords(req_dwords), .req_dst(req_dst),
        .done(done), .outst_cnt(outst_cnt));

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] mk_desc(input logic [47:0] base, input logic [13:0] stride,
                                             input logic [31:0] rec, input logic [33:0] junk);
        return {junk[31:0], rec, junk[33:32], stride, base};
    endfunction

    function automatic logic [47:0] ref_addr(input logic [127:0] d, input logic [31:0] off);
        logic [63:0] st = 64'(d[61:48]);
        logic [63:0] rc = 64'(d[95:64]);
        logic [63:0] o  = 64'(off);
        logic [47:0] s;
        if (st == 0 && o >= rc) o = rc;
        else if (st != 0 && o > st * rc) o = st * rc;
        s = d[47:0] + o[47:0];
        return s & ~48'h3;
    endfunction

    // one load end to end with completion; returns to zero outstanding
    task automatic xfer(input string req, input logic [127:0] d, input logic imm,
                        input logic [OFF_W-1:0] fld, input logic [31:0] sreg,
                        input logic [47:0] exp_addr);
        @(negedge clk);
        in_valid = 1; in_desc = d; in_imm = imm; in_off_field = fld; sreg_rdata = sreg;
        in_size = 3'd4;
        @(negedge clk);
        in_valid = 0;
        check({req, " valid"}, 64'(req_valid), 64'd1);
        check(req, 64'(req_addr), 64'(exp_addr));
        @(negedge clk);
        done = 1;
        @(negedge clk);
        done = 0;
    endtask

    task automatic t_reset;
        check("R12 req_valid", 64'(req_valid), 0);
        check("R12 outst", 64'(outst_cnt), 0);
        check("R12 in_ready", 64'(in_ready), 1);
    endtask

    task automatic t_offset_src;
        logic [127:0] d = mk_desc(48'h1000, 0, 32'hFFFF_FFFF, 0);
        @(negedge clk);
        in_off_field = 20'hA5_F3C;
        check("R1 sreg_sel", 64'(sreg_sel), 64'h3C);
        xfer("R1 imm path", d, 1, 20'h0_0040, 32'h999, 48'h1040);
        xfer("R1 reg path", d, 0, 20'h0_0040, 32'h1234, 48'h2234);
    endtask

    task automatic t_clamp_zero;
        logic [127:0] d = mk_desc(48'h8000, 0, 100, 0);
        xfer("R4 below count", d, 1, 20'd99, 0, ref_addr(d, 99));
        xfer("R2 equal count", d, 1, 20'd100, 0, 48'h8064);
        xfer("R2 above count", d, 0, 0, 32'd200, 48'h8064);
    endtask

    task automatic t_clamp_stride;
        logic [127:0] d = mk_desc(48'h4000, 4, 10, 0);
        logic [127:0] big = mk_desc(48'h0, 14'h3FFF, 32'hFFFF_FFFF, 0);
        xfer("R4 equal product", d, 1, 20'd40, 0, 48'h4028);
        xfer("R3 above product", d, 0, 0, 32'd1000, 48'h4028);
        xfer("R4 below product", d, 1, 20'd39, 0, 48'h4024);
        xfer("R3 wide product no clamp", big, 0, 0, 32'hFFFF_FFFF, 48'hFFFF_FFFC);
    endtask

    task automatic t_align_wrap;
        logic [127:0] d1 = mk_desc(48'hFFFF_FFFF_FFF0, 0, 32'hFFFF, 34'h3_FFFF_FFFF);
        logic [127:0] d0 = mk_desc(48'hFFFF_FFFF_FFF0, 0, 32'hFFFF, 34'h0);
        xfer("R5 wrap and align, junk bits set", d1, 1, 20'h23, 0, 48'h10);
        xfer("R5 junk bits clear", d0, 1, 20'h23, 0, 48'h10);
    endtask

    task automatic t_size;
        for (int s = 0; s < 8; s++) begin
            @(negedge clk);
            in_valid = 1; in_imm = 1; in_off_field = 0; in_size = 3'(s); in_dst = DST_W'(s * 9 + 3);
            in_desc = mk_desc(0, 0, 1, 0);
            @(negedge clk);
            in_valid = 0;
            check("R8 dwords", 64'(req_dwords), (s > 4) ? 64'd16 : (64'd1 << s));
            check("R8 dst", 64'(req_dst), 64'(s * 9 + 3));
            @(negedge clk); done = 1;
            @(negedge clk); done = 0;
        end
    endtask

    task automatic t_backpressure;
        logic [127:0] d = mk_desc(48'h300, 0, 64, 0);
        @(negedge clk);
        req_ready = 0;
        in_valid = 1; in_desc = d; in_imm = 1; in_off_field = 20'h10;
        @(negedge clk);
        in_valid = 0;
        check("R6 valid after one cycle", 64'(req_valid), 1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R7 held valid", 64'(req_valid), 1);
            check("R7 held addr", 64'(req_addr), 48'h310);
            check("R7 in_ready low", 64'(in_ready), 0);
        end
        req_ready = 1;
        #1 check("R7 in_ready with ready", 64'(in_ready), 1);
        @(negedge clk);
        check("R9 issue counted", 64'(outst_cnt), 1);
        check("R7 request gone", 64'(req_valid), 0);
        done = 1;
        @(negedge clk); done = 0;
        check("R9 completion counted", 64'(outst_cnt), 0);
    endtask

    task automatic t_count;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            in_valid = 1; in_imm = 1; in_off_field = 20'(i * 4); in_desc = mk_desc(0, 0, 100, 0);
            @(negedge clk);
            in_valid = 0;
        end
        @(negedge clk);
        check("R9 four outstanding", 64'(outst_cnt), 4);
        check("R11 in_ready at limit", 64'(in_ready), 0);
        in_valid = 1;
        @(negedge clk);
        @(negedge clk);
        check("R11 no request at limit", 64'(req_valid), 0);
        in_valid = 0;
        done = 1;
        @(negedge clk); done = 0;
        check("R9 after done", 64'(outst_cnt), 3);
        check("R11 room again", 64'(in_ready), 1);
        in_valid = 1;
        @(negedge clk);
        in_valid = 0; done = 1;
        @(negedge clk);
        done = 0;
        check("R9 issue with done", 64'(outst_cnt), 3);
        for (int i = 0; i < 3; i++) begin
            done = 1; @(negedge clk);
        end
        done = 0;
        check("R9 drained", 64'(outst_cnt), 0);
        done = 1; @(negedge clk);
        done = 1; @(negedge clk);
        done = 0;
        check("R10 no underflow", 64'(outst_cnt), 0);
        @(negedge clk);
        check("R10 idle ready", 64'(in_ready), 1);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1;
        t_reset();
        t_offset_src();
        t_clamp_zero();
        t_clamp_stride();
        t_align_wrap();
        t_size();
        t_backpressure();
        t_count();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule